// File: doc/BRIEF.md
# Chained TDM Serial Audio Output Port

This block is the serial output stage of one stereo audio device that can be cascaded with identical devices into a single time-division-multiplexed stream. A 64-bit frame register holds one left subframe followed by one right subframe, each 32 bits wide. On the frame boundary it takes the staged sample pair in parallel. Between boundaries it moves one bit per bit-clock period toward its serial output, MSB first. Bits enter at the other end of the register from the chain input pin.

To cascade the ports, wire each device's serial output to the next device's chain input. The devices then behave as one long shift register, and a single receiver at the end of the chain reads N x 64 bits per frame. The bit clock and frame sync come from outside the port, so it always runs as a slave. Both are sampled by the port's fast system clock.

Samples enter over a valid/ready interface into a one-entry staging slot. `smp_ready` is high only while the slot is empty. A sample pair is accepted on a system-clock edge where `smp_valid` and `smp_ready` are both high. The pair is held unchanged until the next frame load empties the slot. While the slot is full, the upstream source must hold off. The port never drops an accepted pair and never accepts over a held one.

Top module: `tdm_chain_port`

## Requirements
- R1: After the synchronous active-low reset, `sdata` is 0 and `smp_ready` is 1.
- R2: A rising edge of `fsync`, as sampled on a rising `bclk` edge, causes a parallel load on the next falling `bclk` edge. On that edge the load replaces the shift. The loaded MSB appears on `sdata` before the following rising `bclk` edge.
- R3: The serial order of a frame is: left subframe bits 31 down to 0, then right subframe bits 31 down to 0.
- R4: Within a subframe, the `SAMPLE_W`-bit audio word occupies bits 31 down to 32-`SAMPLE_W`. Bits 7..0 carry the 8-bit auxiliary field for that channel. Any bits between the two are 0.
- R5: `sdata` changes only on a falling `bclk` edge. It holds while `bclk` is high.
- R6: On each falling `bclk` edge that is not a load, `chain_in` enters at the register LSB. The 64 bits an upstream port shifts out therefore appear on `sdata` in the same order, 64 bit periods later.
- R7: `smp_ready` is high only while the staging slot is empty. It falls after an accepted pair. While it is low, `smp_valid` has no effect: the held pair is the one loaded. A load empties the slot.
- R8: A load that finds the staging slot empty loads an all-zero frame.
- R9: Holding `fsync` high over several `bclk` periods causes only one load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than 2x `bclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock (slave) |
| fsync | input | 1 | Frame sync; rising edge marks a frame |
| chain_in | input | 1 | Serial data from the upstream port |
| smp_valid | input | 1 | Sample pair is valid |
| smp_ready | output | 1 | Staging slot is empty |
| smp_left | input | SAMPLE_W | Left audio sample |
| smp_right | input | SAMPLE_W | Right audio sample |
| smp_aux_left | input | 8 | Left auxiliary byte |
| smp_aux_right | input | 8 | Right auxiliary byte |
| sdata | output | 1 | Serial output to downstream port or receiver |

## Verification
The hardest case to reach is the far half of the chain. The last 64 bits a receiver sees at the downstream port come from a different device of a different sample width, and they pass through the downstream register bit by bit. The bench therefore chains two ports and reads 128 bits per frame from the downstream one. It also varies the frame from pattern to pattern: one frame holds frame sync high over several bit periods, one leaves the downstream slot empty, and one presents a second pair while the slot is full.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;
  localparam int SUBFRAME_W = 32;
  localparam int AUX_W      = 8;
  localparam int FRAME_W    = 2 * SUBFRAME_W;
  localparam int AUDIO_W    = SUBFRAME_W - AUX_W;
endpackage

// File: rtl/tdm_bclk_edges.sv
module tdm_bclk_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  output logic load_o,
  output logic shift_o
);
  logic bclk_q;
  logic fs_q;
  logic pend;
  logic rise;
  logic fall;

  assign rise = bclk & ~bclk_q;
  assign fall = ~bclk & bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
      pend   <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (rise) begin
        fs_q <= fsync;
        if (fsync && !fs_q) pend <= 1'b1;
      end
      if (fall && pend) pend <= 1'b0;
    end
  end

  assign load_o  = fall & pend;
  assign shift_o = fall & ~pend;

  AST_FS_RISE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && fsync && !fs_q) |=> pend); // R2
endmodule

// File: rtl/tdm_sample_stage.sv
module tdm_sample_stage
  import tdm_chain_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic [AUX_W-1:0]    in_aux_l,
  input  logic [AUX_W-1:0]    in_aux_r,
  input  logic                take_i,
  output logic [FRAME_W-1:0]  frame_o
);
  localparam int PAD_W = AUDIO_W - SAMPLE_W;

  logic                full;
  logic [SAMPLE_W-1:0] left_q;
  logic [SAMPLE_W-1:0] right_q;
  logic [AUX_W-1:0]    aux_l_q;
  logic [AUX_W-1:0]    aux_r_q;
  logic                accept;
  logic [AUDIO_W-1:0]  aud_l;
  logic [AUDIO_W-1:0]  aud_r;

  assign in_ready = ~full;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
      aux_l_q <= '0;
      aux_r_q <= '0;
    end else if (accept) begin
      full    <= 1'b1;
      left_q  <= in_left;
      right_q <= in_right;
      aux_l_q <= in_aux_l;
      aux_r_q <= in_aux_r;
    end else if (take_i) begin
      full <= 1'b0;
    end
  end

  assign aud_l   = AUDIO_W'(left_q) << PAD_W;
  assign aud_r   = AUDIO_W'(right_q) << PAD_W;
  assign frame_o = full ? {aud_l, aux_l_q, aud_r, aux_r_q} : '0;

  AST_FULL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready); // R7
  AST_HOLD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ($stable(left_q) && $stable(right_q))); // R7
endmodule

// File: rtl/tdm_frame_shifter.sv
module tdm_frame_shifter
  import tdm_chain_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               chain_in,
  output logic               sdata_o
);
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)       sr <= '0;
    else if (load_i)  sr <= frame_i;
    else if (shift_i) sr <= {sr[FRAME_W-2:0], chain_in};
  end

  assign sdata_o = sr[FRAME_W-1];

  AST_CHAIN_ENTERS_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (sr[0] == $past(chain_in))); // R6
endmodule

// File: rtl/tdm_chain_port.sv
module tdm_chain_port
  import tdm_chain_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                fsync,
  input  logic                chain_in,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic [AUX_W-1:0]    smp_aux_left,
  input  logic [AUX_W-1:0]    smp_aux_right,
  output logic                sdata
);
  logic               ld;
  logic               sh;
  logic [FRAME_W-1:0] frame;

  tdm_bclk_edges u_edges (
    .clk     (clk),
    .rst_n   (rst_n),
    .bclk    (bclk),
    .fsync   (fsync),
    .load_o  (ld),
    .shift_o (sh)
  );

  tdm_sample_stage #(.SAMPLE_W(SAMPLE_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (smp_valid),
    .in_ready (smp_ready),
    .in_left  (smp_left),
    .in_right (smp_right),
    .in_aux_l (smp_aux_left),
    .in_aux_r (smp_aux_right),
    .take_i   (ld),
    .frame_o  (frame)
  );

  tdm_frame_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (ld),
    .shift_i  (sh),
    .frame_i  (frame),
    .chain_in (chain_in),
    .sdata_o  (sdata)
  );

  AST_QUIET_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld || sh) |=> $stable(sdata)); // R5
  AST_LOAD_ON_LOW_BCLK: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> !bclk); // R2
  AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !smp_valid) |=> smp_ready); // R7
  AST_EMPTY_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && smp_ready) |=> !sdata); // R8
endmodule

// File: tb/tb_tdm_chain_port.sv
module tb_tdm_chain_port;
  localparam int WD = 24;
  localparam int WU = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0;
  logic fsync = 1'b0;
  logic link;
  logic sdata;
  logic v_d = 1'b0, v_u = 1'b0;
  logic r_d, r_u;
  logic [WD-1:0] l_d = '0, rr_d = '0;
  logic [WU-1:0] l_u = '0, rr_u = '0;
  logic [7:0] al_d = '0, ar_d = '0, al_u = '0, ar_u = '0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tdm_chain_port #(.SAMPLE_W(WU)) u_up (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .chain_in(1'b0),
    .smp_valid(v_u), .smp_ready(r_u), .smp_left(l_u), .smp_right(rr_u),
    .smp_aux_left(al_u), .smp_aux_right(ar_u), .sdata(link));

  tdm_chain_port #(.SAMPLE_W(WD)) dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .chain_in(link),
    .smp_valid(v_d), .smp_ready(r_d), .smp_left(l_d), .smp_right(rr_d),
    .smp_aux_left(al_d), .smp_aux_right(ar_d), .sdata(sdata));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(input logic [23:0] l, input logic [23:0] r,
                                       input logic [7:0] al, input logic [7:0] ar, input int w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return {((32'(l) & mask) << (32 - w)) | 32'(al), ((32'(r) & mask) << (32 - w)) | 32'(ar)};
  endfunction

  logic [127:0] cap;
  logic sd_hi;
  int stable_bad = 0;

  task automatic bit_cycle(input bit fs, input bit take);
    @(negedge clk);
    if (take) cap = {cap[126:0], sdata};
    sd_hi = sdata;
    fsync = fs;
    bclk = 1'b1;
    @(negedge clk);
    if (sdata !== sd_hi) stable_bad++;
    @(negedge clk);
    bclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(input int hold, input logic [63:0] exp_d, input logic [63:0] exp_u, input string tag);
    bit_cycle(1'b1, 1'b0);
    for (int i = 0; i < 128; i++) bit_cycle(i < hold, 1'b1);
    chk(cap[127:64] === exp_d, {tag, " R2 R3 R4 near frame"}, cap[127:64], exp_d);
    chk(cap[63:0] === exp_u, {tag, " R6 chained frame"}, cap[63:0], exp_u);
  endtask

  task automatic push_d(input logic [23:0] l, input logic [23:0] r, input logic [7:0] al, input logic [7:0] ar);
    @(negedge clk);
    chk(r_d === 1'b1, "R7 ready when empty", 64'(r_d), 64'd1);
    v_d = 1'b1; l_d = l; rr_d = r; al_d = al; ar_d = ar;
    @(negedge clk);
    v_d = 1'b0;
    chk(r_d === 1'b0, "R7 ready low when full", 64'(r_d), 64'd0);
  endtask

  task automatic push_u(input logic [15:0] l, input logic [15:0] r, input logic [7:0] al, input logic [7:0] ar);
    @(negedge clk);
    v_u = 1'b1; l_u = l; rr_u = r; al_u = al; ar_u = ar;
    @(negedge clk);
    v_u = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] ld, rd;
    logic [15:0] lu, ru;
    logic [7:0] ad, bd, au, bu;
    logic [63:0] ed, eu;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sdata === 1'b0, "R1 sdata after reset", 64'(sdata), 64'd0);
    chk(r_d === 1'b1, "R1 ready after reset", 64'(r_d), 64'd1);

    for (int k = 0; k < 8; k++) begin
      ld = 24'(k * 32'h35A1F3 + 32'h800001);
      rd = ~ld ^ 24'(k * 32'h1111);
      lu = 16'(k * 16'h2B73 + 16'h8001);
      ru = ~lu;
      ad = 8'(k * 37 + 5); bd = ~ad; au = 8'(k * 11 + 3); bu = 8'hA0 ^ au;
      if (k == 5) begin
        ld = 24'hFFFFFF; rd = 24'h000000; lu = 16'hFFFF; ru = 16'h0000;
      end
      push_u(lu, ru, au, bu);
      eu = pack(24'(lu), 24'(ru), au, bu, WU);
      if (k == 3) begin
        ed = 64'd0;
        chk(r_d === 1'b1, "R8 slot empty before load", 64'(r_d), 64'd1);
        run_frame(0, ed, eu, "R8 underrun");
      end else begin
        push_d(ld, rd, ad, bd);
        ed = pack(ld, rd, ad, bd, WD);
        if (k == 4) begin
          @(negedge clk);
          v_d = 1'b1; l_d = 24'h123456; rr_d = 24'h654321; al_d = 8'h77; ar_d = 8'h88;
          chk(r_d === 1'b0, "R7 back-pressure while full", 64'(r_d), 64'd0);
          @(negedge clk);
          v_d = 1'b0;
        end
        run_frame((k == 2) ? 6 : 0, ed, eu, (k == 2) ? "R9 held fsync" : "sweep");
        chk(r_d === 1'b1, "R7 ready after load", 64'(r_d), 64'd1);
      end
    end
    chk(stable_bad == 0, "R5 sdata stable while bclk high", 64'(stable_bad), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule